// File: doc/BRIEF.md
# Interruptible Instruction Repeat Counter

This block sequences repeated execution of a co-processor instruction. It holds a 13-bit remaining-repeat count and a flag that marks a repeat sequence in progress. A sequence starts in one of two ways. In the first, a 5-bit immediate gives the number of executions wanted. In the second, the value already in the count register is used, and that value N yields N+1 executions.

The execution unit pulses an iteration-done strobe each time one execution completes. On that strobe the sequencer ends the sequence when the count is zero. Otherwise it decrements the count and keeps requesting executions. An interrupt parks the sequence: the flag stays set, the count freezes at the remaining repetitions minus one, and execution requests stop. A resume request later continues from that point. Software may write the count while the unit is idle or suspended.

Top module: `rep_seq_top`

## Requirements
- R1: After reset the active flag, the suspended flag and the busy output are 0, and the count is 0.
- R2: A start in idle with immediate source and value K (1..31) loads the count with K-1 and sets the active flag. The sequence then yields exactly K iteration-done strobes before the flag clears.
- R3: A start in idle with register source sets the active flag and keeps the count N. The sequence yields exactly N+1 executions.
- R4: An iteration-done strobe while running with a nonzero count decrements the count by one and keeps the flag set.
- R5: An iteration-done strobe while running with a zero count clears the active flag at that clock edge. A later strobe in idle changes neither the flag nor the count.
- R6: A start with immediate source and value 0 does nothing: the flag stays clear and the count is unchanged.
- R7: A count write while running and not suspended is ignored. A count write while idle or suspended is stored.
- R8: An interrupt while running sets the suspended flag and drops busy. The active flag and the count are kept. If iteration-done arrives in the same cycle with a nonzero count, the decrement is applied first. Iteration-done strobes while suspended are ignored.
- R9: A resume while suspended clears the suspended flag and restores busy. A resume when no sequence is suspended is ignored.
- R10: A start request while a sequence is active, whether running or suspended, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cnt_wr_i | input | 1 | Count register write strobe |
| cnt_wdata_i | input | 13 | Count register write data |
| start_i | input | 1 | Start a repeat sequence |
| start_imm_i | input | 1 | 1: immediate source, 0: count register source |
| imm_val_i | input | 5 | Immediate execution count |
| iter_done_i | input | 1 | One execution of the instruction completed |
| irq_i | input | 1 | Interrupt: suspend the running sequence |
| resume_i | input | 1 | Return from interrupt: continue the suspended sequence |
| active_o | output | 1 | Repeat flag, set from start through the last execution |
| suspended_o | output | 1 | Sequence parked by an interrupt |
| busy_o | output | 1 | Another execution is requested |
| count_o | output | 13 | Remaining repetitions minus one |

## Verification
All outputs come from state registers. Each result of a strobe driven before a rising edge is therefore due at that same edge, one cycle after the stimulus, and no output responds combinationally. The bench drives every input on the falling edge and holds it for one full cycle. It samples outputs on the following falling edge, which is half a cycle after the edge that must show the effect. Execution counts are measured by pulsing iteration-done one cycle at a time and counting strobes until the flag drops.

// File: rtl/rep_seq_pkg.sv
package rep_seq_pkg;
  localparam int unsigned CNT_W = 13;
  localparam int unsigned IMM_W = 5;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_SUSP = 2'd2
  } rep_state_e;
endpackage

// File: rtl/rep_seq_ctrl.sv
module rep_seq_ctrl
  import rep_seq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       start_imm_i,
  input  logic       imm_zero_i,
  input  logic       iter_done_i,
  input  logic       irq_i,
  input  logic       resume_i,
  input  logic       cnt_zero_i,
  output rep_state_e state_o,
  output logic       load_imm_o,
  output logic       dec_o,
  output logic       wr_ok_o
);
  rep_state_e state_q, state_d;
  logic       start_ok;

  // immediate zero means no executions at all
  assign start_ok   = start_i && !(start_imm_i && imm_zero_i);
  assign load_imm_o = (state_q == ST_IDLE) && start_ok && start_imm_i;
  assign dec_o      = (state_q == ST_RUN) && iter_done_i && !cnt_zero_i;
  assign wr_ok_o    = (state_q != ST_RUN) && !load_imm_o;
  assign state_o    = state_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_ok) state_d = ST_RUN;
      ST_RUN: begin
        if (iter_done_i && cnt_zero_i) state_d = ST_IDLE;
        else if (irq_i)                state_d = ST_SUSP;
      end
      ST_SUSP: if (resume_i) state_d = ST_RUN;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  p_last_clears_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && iter_done_i && cnt_zero_i) |=> state_q == ST_IDLE);

  p_imm_zero_noop_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && start_i && start_imm_i && imm_zero_i) |=> state_q == ST_IDLE);

  p_irq_parks_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && irq_i && !(iter_done_i && cnt_zero_i)) |=> state_q == ST_SUSP);

  p_resume_idle_ign_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && resume_i && !start_i) |=> state_q == ST_IDLE);

  p_start_busy_ign_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SUSP && start_i && !resume_i) |=> state_q == ST_SUSP);
endmodule

// File: rtl/rep_seq_cnt.sv
module rep_seq_cnt #(
  parameter int unsigned CNT_W = 13,
  parameter int unsigned IMM_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_imm_i,
  input  logic [IMM_W-1:0] imm_val_i,
  input  logic             dec_i,
  input  logic             wr_en_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             zero_o
);
  localparam int unsigned PAD_W = CNT_W - IMM_W;

  logic [CNT_W-1:0] cnt_q, cnt_d, imm_ext;

  assign imm_ext = {{PAD_W{1'b0}}, imm_val_i};

  always_comb begin
    cnt_d = cnt_q;
    if (load_imm_i)   cnt_d = imm_ext - CNT_W'(1);
    else if (dec_i)   cnt_d = cnt_q - CNT_W'(1);
    else if (wr_en_i) cnt_d = wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o  = cnt_q;
  assign zero_o = (cnt_q == '0);

  p_imm_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_imm_i |=> cnt_q == {{PAD_W{1'b0}}, $past(imm_val_i)} - CNT_W'(1));

  p_dec_one_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_i |=> cnt_q == $past(cnt_q) - CNT_W'(1));

  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_imm_i && !dec_i && !wr_en_i) |=> $stable(cnt_q));
endmodule

// File: rtl/rep_seq_top.sv
module rep_seq_top
  import rep_seq_pkg::*;
#(
  parameter int unsigned CW = rep_seq_pkg::CNT_W,
  parameter int unsigned IW = rep_seq_pkg::IMM_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cnt_wr_i,
  input  logic [CW-1:0] cnt_wdata_i,
  input  logic          start_i,
  input  logic          start_imm_i,
  input  logic [IW-1:0] imm_val_i,
  input  logic          iter_done_i,
  input  logic          irq_i,
  input  logic          resume_i,
  output logic          active_o,
  output logic          suspended_o,
  output logic          busy_o,
  output logic [CW-1:0] count_o
);
  rep_state_e state;
  logic       load_imm, dec, wr_ok, cnt_zero;

  rep_seq_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .start_imm_i (start_imm_i),
    .imm_zero_i  (imm_val_i == '0),
    .iter_done_i (iter_done_i),
    .irq_i       (irq_i),
    .resume_i    (resume_i),
    .cnt_zero_i  (cnt_zero),
    .state_o     (state),
    .load_imm_o  (load_imm),
    .dec_o       (dec),
    .wr_ok_o     (wr_ok)
  );

  rep_seq_cnt #(.CNT_W(CW), .IMM_W(IW)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_imm_i (load_imm),
    .imm_val_i  (imm_val_i),
    .dec_i      (dec),
    .wr_en_i    (cnt_wr_i && wr_ok),
    .wdata_i    (cnt_wdata_i),
    .cnt_o      (count_o),
    .zero_o     (cnt_zero)
  );

  assign active_o    = (state != ST_IDLE);
  assign suspended_o = (state == ST_SUSP);
  assign busy_o      = (state == ST_RUN);

  p_run_wr_ign_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && cnt_wr_i && !iter_done_i) |=> $stable(count_o));

  p_susp_done_ign_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (suspended_o && iter_done_i && !cnt_wr_i) |=> $stable(count_o));

  p_susp_keeps_flag_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    suspended_o |-> active_o && !busy_o);
endmodule

// File: tb/rep_seq_top_tb.sv
`timescale 1ns/1ps
module rep_seq_top_tb;
  localparam int unsigned CW = 13;
  localparam int unsigned IW = 5;

  typedef struct packed {
    logic [IW-1:0] imm;
    logic [CW-1:0] cnt;
    logic [15:0]   runs;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{imm: 5'd1,  cnt: 13'd0,  runs: 16'd1},
    '{imm: 5'd2,  cnt: 13'd1,  runs: 16'd2},
    '{imm: 5'd5,  cnt: 13'd4,  runs: 16'd5},
    '{imm: 5'd24, cnt: 13'd23, runs: 16'd24},
    '{imm: 5'd31, cnt: 13'd30, runs: 16'd31},
    '{imm: 5'd0,  cnt: 13'd0,  runs: 16'd0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic cnt_wr = 0, start = 0, start_imm = 0, iter_done = 0, irq = 0, resume = 0;
  logic [CW-1:0] wdata = '0;
  logic [IW-1:0] imm = '0;
  logic active, suspended, busy;
  logic [CW-1:0] count;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  rep_seq_top u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cnt_wr_i(cnt_wr), .cnt_wdata_i(wdata),
    .start_i(start), .start_imm_i(start_imm), .imm_val_i(imm),
    .iter_done_i(iter_done), .irq_i(irq), .resume_i(resume),
    .active_o(active), .suspended_o(suspended), .busy_o(busy), .count_o(count)
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_start(bit use_imm, logic [IW-1:0] v);
    start = 1; start_imm = use_imm; imm = v;
    @(negedge clk);
    start = 0; start_imm = 0; imm = '0;
  endtask

  task automatic do_done();
    iter_done = 1; @(negedge clk); iter_done = 0;
  endtask

  task automatic do_write(logic [CW-1:0] v);
    cnt_wr = 1; wdata = v; @(negedge clk); cnt_wr = 0; wdata = '0;
  endtask

  task automatic do_irq();
    irq = 1; @(negedge clk); irq = 0;
  endtask

  task automatic do_resume();
    resume = 1; @(negedge clk); resume = 0;
  endtask

  task automatic drain(output int n, input int limit);
    n = 0;
    while (active && n < limit) begin
      do_done();
      n++;
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    int n;
    repeat (2) @(negedge clk);
    // R1 reset state
    chk("R1 active", active, 0);
    chk("R1 suspended", suspended, 0);
    chk("R1 busy", busy, 0);
    chk("R1 count", count, 0);
    rst_n = 1;
    @(negedge clk);

    // table: immediate starts (R2) and zero immediate (R6)
    for (int i = 0; i < 6; i++) begin
      do_start(1'b1, VECS[i].imm);
      chk(VECS[i].runs == 0 ? "R6 active" : "R2 active", active, (VECS[i].runs != 0) ? 1 : 0);
      chk(VECS[i].runs == 0 ? "R6 count" : "R2 count", count, VECS[i].cnt);
      drain(n, 40);
      chk("R2 executions", n, VECS[i].runs);
    end

    // R7 idle write, R3 register start N+1 executions
    do_write(13'd255);
    chk("R7 idle write", count, 255);
    do_start(1'b0, 5'd0);
    chk("R3 active", active, 1);
    chk("R3 count kept", count, 255);
    drain(n, 400);
    chk("R3 executions", n, 256);
    // R5 strobe after end has no effect
    chk("R5 flag cleared", active, 0);
    do_done();
    chk("R5 late strobe active", active, 0);
    chk("R5 late strobe count", count, 0);

    // R4 decrement
    do_start(1'b1, 5'd5);
    do_done();
    chk("R4 count", count, 3);
    chk("R4 active", active, 1);
    // R7 write while running ignored
    do_write(13'd100);
    chk("R7 run write ignored", count, 3);
    // R8 interrupt
    do_irq();
    chk("R8 suspended", suspended, 1);
    chk("R8 active kept", active, 1);
    chk("R8 busy", busy, 0);
    chk("R8 count kept", count, 3);
    do_done();
    chk("R8 done ignored", count, 3);
    // R7 write while suspended accepted
    do_write(13'd7);
    chk("R7 suspended write", count, 7);
    // R10 start while suspended ignored
    do_start(1'b1, 5'd20);
    chk("R10 suspended start", count, 7);
    chk("R10 still suspended", suspended, 1);
    // R9 resume
    do_resume();
    chk("R9 suspended cleared", suspended, 0);
    chk("R9 busy", busy, 1);
    drain(n, 40);
    chk("R9 resumed executions", n, 8);
    do_resume();
    chk("R9 idle resume ignored", active, 0);
    chk("R9 idle resume busy", busy, 0);

    // R10 start while running ignored
    do_start(1'b1, 5'd3);
    do_start(1'b1, 5'd10);
    chk("R10 running start", count, 2);
    // R8 interrupt with simultaneous done
    irq = 1; iter_done = 1; @(negedge clk); irq = 0; iter_done = 0;
    chk("R8 same-cycle count", count, 1);
    chk("R8 same-cycle suspended", suspended, 1);
    do_resume();
    drain(n, 40);
    chk("R8 remaining executions", n, 2);

    finished = 1;
    summary();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      summary();
    end
  end
endmodule